// File: doc/BRIEF.md
# I2C Stereo Attenuation Register Slave

This block is a write-only I2C target that holds the volume state of a two-channel attenuator. A microcontroller addresses it, then sends command bytes. The block keeps a left and a right attenuation in whole decibels from 0 to 79, plus a mute flag for each side. Both bus lines are synchronised to the system clock and oversampled, so the bus must run well below the system clock rate. The acknowledge is driven through an open-drain enable: when that output is high, SDA is pulled low.

A volume setting is split over two command bytes: one carries the tens digit and the other the units digit. The setting reaches the outputs only when both digits for the same channel group arrive as back-to-back data bytes in one transaction. They may come in either order. The first digit waits in a pending stage. A start, a stop, or any other byte in between discards that stage. Mute and clear act as soon as they are acknowledged.

Top module: `i2c_atten_slave`

## Requirements
- R1: The address byte 0x88 is acknowledged on the ninth clock. Any other address byte, including 0x89, gets no acknowledge, and the data bytes that follow in that transaction get no acknowledge and change no output.
- R2: Recognised command bytes are acknowledged. A units code with a value of 10 to 15, and any unrecognised byte, are not acknowledged.
- R3: After reset, both attenuation outputs and both mute outputs are 0. Each attenuation output equals 10 × tens + units and never exceeds 79.
- R4: The volume codes are as follows. 1101_uuuu and 1110_0ttt address both channels. 1010_uuuu and 1011_0ttt address the left channel. 0010_uuuu and 0011_0ttt address the right channel. A tens code and a units code for the same group, sent as consecutive data bytes of one transaction, update that group in either order.
- R5: A lone tens or units code has no effect on the outputs. The same holds for a pair separated by another byte, a pair for different groups, or a pair split by a stop or a repeated start.
- R6: The byte 0111_11cm sets the mute outputs at once: c (bit 1) drives the left mute and m (bit 0) drives the right mute.
- R7: The byte 0xF0 zeroes both attenuations and both mutes, and discards any pending digit.
- R8: A start is SDA falling while SCL is high. A stop is SDA rising while SCL is high. Data bits are taken on SCL rising, most significant bit first.
- R9: The acknowledge pull-down is released once SCL falls at the end of the acknowledge clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line as seen at the pin |
| sda_i | input | 1 | I2C data line as seen at the pin |
| sda_oe | output | 1 | High pulls SDA low (open-drain acknowledge) |
| atten_l | output | 7 | Left attenuation in dB, 0 to 79 |
| atten_r | output | 7 | Right attenuation in dB, 0 to 79 |
| mute_l | output | 1 | Left channel mute |
| mute_r | output | 1 | Right channel mute |

## Verification
A bad bit counter or a bad shift register shows up within one byte, as a missing or misplaced acknowledge on the ninth clock. A pending stage that is not cleared shows up only one transaction later, when a lone digit combines with the leftover and moves an attenuation output that should have held. The stimulus therefore places lone codes, interleaved codes and split pairs just after valid pairs. Any output change is checked against the clock-fall timing that only a byte boundary can produce.

// File: rtl/i2c_atten_slave.sv
module i2c_atten_slave #(
  parameter logic [7:0] DEV_ADDR = 8'h88,
  parameter int         SYNC     = 2,
  parameter int         ATT_W    = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  output logic [ATT_W-1:0] atten_l,
  output logic [ATT_W-1:0] atten_r,
  output logic             mute_l,
  output logic             mute_r
);
  logic [SYNC-1:0] scl_q, sda_q;
  logic scl_p, sda_p;
  wire scl_s = scl_q[SYNC-1];
  wire sda_s = sda_q[SYNC-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= '1; sda_q <= '1; scl_p <= 1'b1; sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[SYNC-2:0], scl_i};
      sda_q <= {sda_q[SYNC-2:0], sda_i};
      scl_p <= scl_s;
      sda_p <= sda_s;
    end

  wire scl_rise = scl_s & ~scl_p;
  wire scl_fall = ~scl_s & scl_p;
  wire start_c  = scl_s & scl_p & sda_p & ~sda_s;
  wire stop_c   = scl_s & scl_p & ~sda_p & sda_s;

  logic       in_frame, first, selected, ack_ph;
  logic [3:0] cnt;
  logic [7:0] sh;
  logic       pend_v, pend_t;
  logic [1:0] pend_g;
  logic [3:0] pend_n;

  logic       is_vol, is_tens;
  logic [1:0] grp;
  wire is_clr  = (sh == 8'hF0);
  wire is_mute = (sh[7:2] == 6'b011111);

  always_comb begin
    is_vol = 1'b0; is_tens = 1'b0; grp = 2'b00;
    case (sh[7:4])
      4'hD: begin is_vol = 1'b1;    grp = 2'b11; end
      4'hE: begin is_vol = ~sh[3];  is_tens = 1'b1; grp = 2'b11; end
      4'hA: begin is_vol = 1'b1;    grp = 2'b10; end
      4'hB: begin is_vol = ~sh[3];  is_tens = 1'b1; grp = 2'b10; end
      4'h2: begin is_vol = 1'b1;    grp = 2'b01; end
      4'h3: begin is_vol = ~sh[3];  is_tens = 1'b1; grp = 2'b01; end
      default: ;
    endcase
  end

  wire       vol_ok  = is_vol & (is_tens | (sh[3:0] <= 4'd9));
  wire       cmd_ok  = is_clr | is_mute | vol_ok;
  wire       pair    = pend_v & (pend_g == grp) & (pend_t != is_tens);
  wire [2:0] tens_v  = is_tens ? sh[2:0] : pend_n[2:0];
  wire [3:0] unit_v  = is_tens ? pend_n : sh[3:0];
  wire [ATT_W-1:0] sum = ATT_W'(tens_v) * ATT_W'(10) + ATT_W'(unit_v);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      in_frame <= 1'b0; first <= 1'b0; selected <= 1'b0; ack_ph <= 1'b0;
      cnt <= '0; sh <= '0; sda_oe <= 1'b0;
      pend_v <= 1'b0; pend_t <= 1'b0; pend_g <= '0; pend_n <= '0;
      atten_l <= '0; atten_r <= '0; mute_l <= 1'b0; mute_r <= 1'b0;
    end else if (start_c) begin
      in_frame <= 1'b1; first <= 1'b1; selected <= 1'b0; ack_ph <= 1'b0;
      cnt <= '0; sda_oe <= 1'b0; pend_v <= 1'b0;
    end else if (stop_c) begin
      in_frame <= 1'b0; selected <= 1'b0; ack_ph <= 1'b0;
      sda_oe <= 1'b0; pend_v <= 1'b0;
    end else if (in_frame) begin
      if (scl_rise && !ack_ph && cnt != 4'd8) begin
        sh  <= {sh[6:0], sda_s};
        cnt <= cnt + 4'd1;
      end else if (scl_fall && ack_ph) begin
        ack_ph <= 1'b0; sda_oe <= 1'b0; cnt <= '0;
      end else if (scl_fall && cnt == 4'd8) begin
        ack_ph <= 1'b1;
        if (first) begin
          first    <= 1'b0;
          selected <= (sh == DEV_ADDR);
          sda_oe   <= (sh == DEV_ADDR);
        end else if (selected) begin
          sda_oe <= cmd_ok;
          if (is_clr) begin
            atten_l <= '0; atten_r <= '0; mute_l <= 1'b0; mute_r <= 1'b0;
            pend_v  <= 1'b0;
          end else if (is_mute) begin
            mute_l <= sh[1]; mute_r <= sh[0]; pend_v <= 1'b0;
          end else if (vol_ok && pair) begin
            if (grp[1]) atten_l <= sum;
            if (grp[0]) atten_r <= sum;
            pend_v <= 1'b0;
          end else if (vol_ok) begin
            pend_v <= 1'b1; pend_t <= is_tens; pend_g <= grp;
            pend_n <= is_tens ? {1'b0, sh[2:0]} : sh[3:0];
          end else begin
            pend_v <= 1'b0;
          end
        end
      end
    end
endmodule

// File: rtl/i2c_atten_slave_chk.sv
module i2c_atten_slave_chk #(
  parameter int ATT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_s,
  input logic             scl_fall,
  input logic             in_frame,
  input logic             sda_oe,
  input logic [ATT_W-1:0] atten_l,
  input logic [ATT_W-1:0] atten_r,
  input logic             mute_l,
  input logic             mute_r
);
  p_atten_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (atten_l <= ATT_W'(79)) && (atten_r <= ATT_W'(79)));

  p_atten_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({atten_l, atten_r}) |-> $past(scl_fall));

  p_mute_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({mute_l, mute_r}) |-> $past(scl_fall));

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_frame |-> !sda_oe);

  p_ack_low_clk_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  p_ack_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe && scl_fall) |=> !sda_oe);
endmodule

bind i2c_atten_slave i2c_atten_slave_chk #(.ATT_W(ATT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .scl_fall(scl_fall),
  .in_frame(in_frame), .sda_oe(sda_oe), .atten_l(atten_l),
  .atten_r(atten_r), .mute_l(mute_l), .mute_r(mute_r)
);

// File: tb/i2c_atten_slave_tb.sv
`timescale 1ns/1ps
module i2c_atten_slave_tb;
  localparam int Q  = 250;
  localparam int NV = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe, mute_l, mute_r;
  logic [6:0] atten_l, atten_r;
  wire sda_line = m_sda & ~sda_oe;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  i2c_atten_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .atten_l(atten_l), .atten_r(atten_r),
    .mute_l(mute_l), .mute_r(mute_r)
  );

  // {count, b0, b1, b2, ack mask (b0 at bit 2), atten_l, atten_r, mute_l, mute_r}
  localparam logic [44:0] VEC [NV] = '{
    {2'd2, 8'hE4, 8'hD2, 8'h00, 3'b110, 7'd42, 7'd42, 1'b0, 1'b0},
    {2'd2, 8'hD5, 8'hE3, 8'h00, 3'b110, 7'd35, 7'd35, 1'b0, 1'b0},
    {2'd2, 8'hB1, 8'hA7, 8'h00, 3'b110, 7'd17, 7'd35, 1'b0, 1'b0},
    {2'd2, 8'h22, 8'h36, 8'h00, 3'b110, 7'd17, 7'd62, 1'b0, 1'b0},
    {2'd1, 8'hE1, 8'h00, 8'h00, 3'b100, 7'd17, 7'd62, 1'b0, 1'b0},
    {2'd1, 8'hD9, 8'h00, 8'h00, 3'b100, 7'd17, 7'd62, 1'b0, 1'b0},
    {2'd3, 8'hE2, 8'h27, 8'hD3, 3'b111, 7'd17, 7'd62, 1'b0, 1'b0},
    {2'd1, 8'h7D, 8'h00, 8'h00, 3'b100, 7'd17, 7'd62, 1'b0, 1'b1},
    {2'd1, 8'h7E, 8'h00, 8'h00, 3'b100, 7'd17, 7'd62, 1'b1, 1'b0},
    {2'd1, 8'h7F, 8'h00, 8'h00, 3'b100, 7'd17, 7'd62, 1'b1, 1'b1},
    {2'd2, 8'hDA, 8'hE0, 8'h00, 3'b010, 7'd17, 7'd62, 1'b1, 1'b1},
    {2'd1, 8'hF0, 8'h00, 8'h00, 3'b100, 7'd0,  7'd0,  1'b0, 1'b0},
    {2'd2, 8'hE7, 8'hD9, 8'h00, 3'b110, 7'd79, 7'd79, 1'b0, 1'b0},
    {2'd3, 8'hB7, 8'h7C, 8'hA9, 3'b111, 7'd79, 7'd79, 1'b0, 1'b0},
    {2'd3, 8'hB2, 8'hA3, 8'h35, 3'b111, 7'd23, 7'd79, 1'b0, 1'b0},
    {2'd3, 8'hE5, 8'h55, 8'hD5, 3'b101, 7'd23, 7'd79, 1'b0, 1'b0}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; #Q; m_scl = 1'b1; #Q; m_sda = 1'b0; #Q; m_scl = 1'b0; #Q;
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; #Q; m_scl = 1'b1; #Q; m_sda = 1'b1; #Q;
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; #Q; m_scl = 1'b1; #(2*Q); m_scl = 1'b0; #Q;
    end
    m_sda = 1'b1; #Q; m_scl = 1'b1; #Q;
    ack = (sda_line == 1'b0);
    #Q; m_scl = 1'b0; #Q;
    if (ack) chk(sda_oe == 1'b0, "R9 release", int'(sda_oe), 0);
  endtask

  task automatic chk_out(input string tag, input int al, input int ar, input int ml, input int mr);
    chk(atten_l == al, {tag, " left atten"}, int'(atten_l), al);
    chk(atten_r == ar, {tag, " right atten"}, int'(atten_r), ar);
    chk({mute_l, mute_r} == 2'(ml * 2 + mr), {tag, " mutes"}, int'({mute_l, mute_r}), ml * 2 + mr);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] bb [3];
    #50; rst_n = 1'b1; #50;
    chk_out("R3 reset", 0, 0, 0, 0);
    chk(sda_oe == 1'b0, "R3 reset oe", int'(sda_oe), 0);

    for (int v = 0; v < NV; v++) begin
      bb[0] = VEC[v][42:35]; bb[1] = VEC[v][34:27]; bb[2] = VEC[v][26:19];
      i2c_start();
      wbyte(8'h88, a);
      chk(a == 1'b1, "R1 address ack", int'(a), 1);
      for (int k = 0; k < 3; k++) begin
        if (k < int'(VEC[v][44:43])) begin
          wbyte(bb[k], a);
          chk(a == VEC[v][18-k], "R2 command ack", int'(a), int'(VEC[v][18-k]));
        end
      end
      i2c_stop(); #100;
      chk_out("R4/R5/R8 vector", int'(VEC[v][15:9]), int'(VEC[v][8:2]),
              int'(VEC[v][1]), int'(VEC[v][0]));
    end

    // R1: foreign addresses, including the read direction
    i2c_start(); wbyte(8'h8A, a);
    chk(a == 1'b0, "R1 wrong address", int'(a), 0);
    wbyte(8'hE0, a); chk(a == 1'b0, "R1 ignored byte", int'(a), 0);
    wbyte(8'hD0, a); chk(a == 1'b0, "R1 ignored byte", int'(a), 0);
    i2c_stop(); #100;
    chk_out("R1 no change", 23, 79, 0, 0);
    i2c_start(); wbyte(8'h89, a);
    chk(a == 1'b0, "R1 read address", int'(a), 0);
    wbyte(8'hF0, a); i2c_stop(); #100;
    chk_out("R1 no clear", 23, 79, 0, 0);

    // R5: stop between the digits
    i2c_start(); wbyte(8'h88, a); wbyte(8'hE1, a); i2c_stop();
    i2c_start(); wbyte(8'h88, a); wbyte(8'hD1, a); i2c_stop(); #100;
    chk_out("R5 stop split", 23, 79, 0, 0);

    // R5: repeated start between the digits
    i2c_start(); wbyte(8'h88, a); wbyte(8'hE1, a);
    i2c_start(); wbyte(8'h88, a); wbyte(8'hD1, a); i2c_stop(); #100;
    chk_out("R5 restart split", 23, 79, 0, 0);

    // R7: clear discards a pending digit
    i2c_start(); wbyte(8'h88, a); wbyte(8'hE3, a); wbyte(8'hF0, a);
    wbyte(8'hD3, a); i2c_stop(); #100;
    chk_out("R7 clear drops pending", 0, 0, 0, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule